// File: doc/BRIEF.md
# Fractional-N Divider Modulus Controller

This block produces, on every reference-clock cycle, the integer modulus that a synthesizer's variable feedback divider should use. Software-style configuration inputs describe the channel: a band-select bit, a five-bit band field that fixes the integer part, and a fraction in steps of one part in 64000 of the reference. A receive/transmit flag, a deviation word and the serial transmit bit are folded into that fraction digitally. In receive mode the fraction is lowered by the intermediate-frequency offset. In transmit mode it is raised or lowered by the deviation. Any carry or borrow moves the integer part.

The resulting effective fraction drives a third-order cascade of error-feedback accumulators that wrap at 64000. The combined carries give a signed offset from -3 to +4, which is added to the integer part. Over many cycles the average modulus therefore equals the integer part plus fraction/64000. The block also reports the output-divider choice that goes with the band. Each time the synthesizer is enabled, it raises a one-cycle request for capacitor-bank calibration, unless a skip control is set for fast hopping.

Top module: `fracn_mod_ctrl`

## Requirements
- R1: While rstN is low, modulus, calReq and outDivSel are all zero.
- R2: The integer part is 24 + bandField, moved by the carry or borrow of R5. outDivSel equals bandSel sampled one clock earlier.
- R3: Step units depend on the band. With bandSel=0, the IF offset is 6000 steps and one devWord unit is 4 steps. With bandSel=1, the IF offset is 3000 steps and one devWord unit is 2 steps.
- R4: With rxMode=1, the effective fraction is chanFrac minus the IF offset, and devWord and txData have no effect. With rxMode=0, txData=1 adds the deviation steps and txData=0 subtracts them.
- R5: An effective fraction below 0 gets 64000 added and takes 1 from the integer part. One at or above 64000 has 64000 removed and adds 1 to the integer part.
- R6: While enabled, modulus equals the integer part plus a third-order cascade offset in the range -3..+4. Over 4000 cycles the mean modulus is within 0.001 of integer + fraction/64000.
- R7: While synthEn is low, and on the first enabled cycle, the accumulators are cleared. The modulus then equals the integer part exactly.
- R8: A rising synthEn with skipCal=0 gives calReq high for exactly one cycle, on the next clock. With skipCal=1 there is no calReq.
- R9: All inputs are sampled at a clock edge. The effective word takes effect in the modulus one clock later, and the modulus changes only at clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one modulator step per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| synthEn | input | 1 | Synthesizer enable |
| skipCal | input | 1 | Suppress calibration request on enable |
| bandSel | input | 1 | Band select: 0 fine steps, 1 coarse steps |
| bandField | input | 5 | Integer part selector |
| chanFrac | input | 16 | Carrier fraction in 1/64000 steps |
| rxMode | input | 1 | 1 = receive, 0 = transmit |
| devWord | input | 10 | Deviation magnitude in 625 Hz units |
| txData | input | 1 | Serial transmit bit, 1 = mark |
| modulus | output | 8 | Instantaneous divider modulus |
| outDivSel | output | 1 | Output divider choice for the band |
| calReq | output | 1 | One-cycle calibration request |

## Verification
A corrupted accumulator or a stale delayed carry shows at the modulus on the next clock. The per-cycle comparison against a behavioural model catches it at once, even when the long-run mean would recover. A wrong step conversion or a wrong wrap rule leaves every cycle plausible but shifts the mean. The averaging checks expose this within one 4000-cycle window per case. A fault in the enable-edge logic shows as a missing, doubled or unwanted calReq within one cycle of the edge.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int DEN_DEF     = 64000;
  localparam int FRAC_W_DEF  = 16;
  localparam int MOD_W_DEF   = 8;
  localparam int BAND_W_DEF  = 5;
  localparam int DEV_W_DEF   = 10;
  localparam int BASE_DEF    = 24;
  localparam int IF_LO_DEF   = 6000;
  localparam int ORDER_DEF   = 3;

  typedef struct packed {
    logic clear;
    logic step;
    logic calPulse;
  } ctrlStrobe_t;
endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        synthEn,
  input  logic        skipCal,
  output ctrlStrobe_t strobe,
  output logic        calReq
);
  logic enDelay;

  always_comb begin
    strobe.clear    = !synthEn || !enDelay;
    strobe.step     = synthEn && enDelay;
    strobe.calPulse = synthEn && !enDelay && !skipCal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enDelay <= 1'b0;
      calReq  <= 1'b0;
    end else begin
      enDelay <= synthEn;
      calReq  <= strobe.calPulse;
    end
  end
endmodule

// File: rtl/fracn_word.sv
module fracn_word #(
  parameter int DEN    = 64000,
  parameter int FRAC_W = 16,
  parameter int MOD_W  = 8,
  parameter int BAND_W = 5,
  parameter int DEV_W  = 10,
  parameter int BASE   = 24,
  parameter int IF_LO  = 6000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bandSel,
  input  logic [BAND_W-1:0] bandField,
  input  logic [FRAC_W-1:0] chanFrac,
  input  logic              rxMode,
  input  logic [DEV_W-1:0]  devWord,
  input  logic              txData,
  output logic [FRAC_W-1:0] effFrac,
  output logic [MOD_W-1:0]  effInt,
  output logic              outDivSel
);
  localparam int SUM_W = FRAC_W + 3;
  localparam logic signed [SUM_W-1:0] DEN_S = SUM_W'(DEN);

  logic signed [SUM_W-1:0] ifStep, devStep, delta, rawSum, normSum;
  logic intInc, intDec;
  logic [MOD_W-1:0] nextInt;

  always_comb begin
    ifStep  = bandSel ? $signed(SUM_W'(IF_LO / 2)) : $signed(SUM_W'(IF_LO));
    devStep = bandSel ? $signed(SUM_W'({devWord, 1'b0})) : $signed(SUM_W'({devWord, 2'b00}));
    if (rxMode)      delta = -ifStep;
    else if (txData) delta = devStep;
    else             delta = -devStep;
    rawSum  = $signed(SUM_W'(chanFrac)) + delta;
    intInc  = 1'b0;
    intDec  = 1'b0;
    normSum = rawSum;
    if (rawSum < 0) begin
      normSum = rawSum + DEN_S;
      intDec  = 1'b1;
    end else if (rawSum >= DEN_S) begin
      normSum = rawSum - DEN_S;
      intInc  = 1'b1;
    end
    nextInt = MOD_W'(BASE) + MOD_W'(bandField) + MOD_W'(intInc) - MOD_W'(intDec);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effFrac   <= '0;
      effInt    <= '0;
      outDivSel <= 1'b0;
    end else begin
      effFrac   <= FRAC_W'(normSum);
      effInt    <= nextInt;
      outDivSel <= bandSel;
    end
  end
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_pkg::*;
#(
  parameter int DEN    = 64000,
  parameter int FRAC_W = 16,
  parameter int MOD_W  = 8,
  parameter int ORDER  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic [MOD_W-1:0]  intPart,
  output logic [MOD_W-1:0]  modulus
);
  localparam logic [FRAC_W:0] DEN_W = (FRAC_W+1)'(DEN);

  logic [FRAC_W-1:0] acc     [ORDER];
  logic [FRAC_W-1:0] accNext [ORDER];
  logic [FRAC_W:0]   sumS    [ORDER];
  logic [ORDER-1:0]  carry;
  logic c2Dly, c3Dly, c3Dly2;
  logic signed [3:0] offset;
  logic [MOD_W-1:0] modNext;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sumS[g] = {1'b0, acc[g]} + {1'b0, fracIn};
    end else begin : g_next
      assign sumS[g] = {1'b0, acc[g]} + {1'b0, accNext[g-1]};
    end
    assign carry[g]   = (sumS[g] >= DEN_W);
    assign accNext[g] = carry[g] ? FRAC_W'(sumS[g] - DEN_W) : FRAC_W'(sumS[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             acc[g] <= '0;
      else if (strobe.clear) acc[g] <= '0;
      else if (strobe.step)  acc[g] <= accNext[g];
    end
  end

  always_comb begin
    offset  = 4'(carry[0]) + 4'(carry[1]) - 4'(c2Dly)
            + 4'(carry[2]) - 4'({c3Dly, 1'b0}) + 4'(c3Dly2);
    modNext = intPart + MOD_W'(offset);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2Dly   <= 1'b0;
      c3Dly   <= 1'b0;
      c3Dly2  <= 1'b0;
      modulus <= '0;
    end else if (strobe.clear) begin
      c2Dly   <= 1'b0;
      c3Dly   <= 1'b0;
      c3Dly2  <= 1'b0;
      modulus <= intPart;
    end else if (strobe.step) begin
      c2Dly   <= carry[1];
      c3Dly   <= carry[2];
      c3Dly2  <= c3Dly;
      modulus <= modNext;
    end
  end
endmodule

// File: rtl/fracn_mod_ctrl.sv
module fracn_mod_ctrl
  import fracn_pkg::*;
#(
  parameter int DEN    = DEN_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int MOD_W  = MOD_W_DEF,
  parameter int BAND_W = BAND_W_DEF,
  parameter int DEV_W  = DEV_W_DEF,
  parameter int BASE   = BASE_DEF,
  parameter int IF_LO  = IF_LO_DEF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              synthEn,
  input  logic              skipCal,
  input  logic              bandSel,
  input  logic [BAND_W-1:0] bandField,
  input  logic [FRAC_W-1:0] chanFrac,
  input  logic              rxMode,
  input  logic [DEV_W-1:0]  devWord,
  input  logic              txData,
  output logic [MOD_W-1:0]  modulus,
  output logic              outDivSel,
  output logic              calReq
);
  ctrlStrobe_t       strobe;
  logic [FRAC_W-1:0] effFrac;
  logic [MOD_W-1:0]  effInt;

  fracn_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .synthEn(synthEn), .skipCal(skipCal),
    .strobe(strobe), .calReq(calReq)
  );

  fracn_word #(
    .DEN(DEN), .FRAC_W(FRAC_W), .MOD_W(MOD_W), .BAND_W(BAND_W),
    .DEV_W(DEV_W), .BASE(BASE), .IF_LO(IF_LO)
  ) u_word (
    .clk(clk), .rstN(rstN), .bandSel(bandSel), .bandField(bandField),
    .chanFrac(chanFrac), .rxMode(rxMode), .devWord(devWord), .txData(txData),
    .effFrac(effFrac), .effInt(effInt), .outDivSel(outDivSel)
  );

  fracn_mash #(
    .DEN(DEN), .FRAC_W(FRAC_W), .MOD_W(MOD_W), .ORDER(3)
  ) u_mash (
    .clk(clk), .rstN(rstN), .strobe(strobe), .fracIn(effFrac),
    .intPart(effInt), .modulus(modulus)
  );
endmodule

// File: rtl/fracn_chk.sv
module fracn_chk #(
  parameter int MOD_W  = 8,
  parameter int BAND_W = 5,
  parameter int BASE   = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             synthEn,
  input logic             skipCal,
  input logic             bandSel,
  input logic [MOD_W-1:0] modulus,
  input logic             outDivSel,
  input logic             calReq
);
  localparam int MOD_MIN = BASE - 4;
  localparam int MOD_MAX = BASE + (1 << BAND_W) + 4;

  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_CAL_SOURCE: assert property (@(posedge clk) disable iff (!rstN || warm != 2'd3)
    calReq |-> ($past(synthEn) && !$past(synthEn, 2) && !$past(skipCal))); // R8
  AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rstN || warm != 2'd3)
    calReq |=> !calReq); // R8
  AST_CAL_SKIPPED: assert property (@(posedge clk) disable iff (!rstN || warm != 2'd3)
    $past(skipCal) |-> !calReq); // R8
  AST_BAND_DIV: assert property (@(posedge clk) disable iff (!rstN || warm != 2'd3)
    outDivSel == $past(bandSel)); // R2
  AST_MOD_RANGE: assert property (@(posedge clk) disable iff (!rstN || warm != 2'd3)
    (int'(modulus) >= MOD_MIN) && (int'(modulus) <= MOD_MAX)); // R6
endmodule

bind fracn_mod_ctrl fracn_chk #(
  .MOD_W(MOD_W), .BAND_W(BAND_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .synthEn(synthEn), .skipCal(skipCal),
  .bandSel(bandSel), .modulus(modulus), .outDivSel(outDivSel), .calReq(calReq)
);

// File: tb/sim_fracn_mod_ctrl.sv
module sim_fracn_mod_ctrl;
  localparam int DEN  = 64000;
  localparam int BASE = 24;
  localparam int NAVG = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic synthEn = 0, skipCal = 0, bandSel = 0, rxMode = 0, txData = 0;
  logic [4:0]  bandField = '0;
  logic [15:0] chanFrac = '0;
  logic [9:0]  devWord = '0;
  logic [7:0]  modulus;
  logic        outDivSel, calReq;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fracn_mod_ctrl u0 (
    .clk(clk), .rstN(rstN), .synthEn(synthEn), .skipCal(skipCal),
    .bandSel(bandSel), .bandField(bandField), .chanFrac(chanFrac),
    .rxMode(rxMode), .devWord(devWord), .txData(txData),
    .modulus(modulus), .outDivSel(outDivSel), .calReq(calReq)
  );

  // behavioural reference model
  int mA [3];
  int mC2d = 0, mC3d = 0, mC3dd = 0, mFrac = 0, mInt = 0;
  int expMod = 0, expCal = 0, expDiv = 0;
  bit mEnPrev = 0;

  always @(posedge clk) begin : model
    int s, ifs, dv, ni, inV, y;
    int c [3];
    bit rise;
    if (rstN) begin
      ifs = bandSel ? 3000 : 6000;
      dv  = bandSel ? int'(devWord) * 2 : int'(devWord) * 4;
      s   = int'(chanFrac) + (rxMode ? -ifs : (txData ? dv : -dv));
      ni  = BASE + int'(bandField);
      if (s < 0) begin s += DEN; ni -= 1; end
      else if (s >= DEN) begin s -= DEN; ni += 1; end
      rise   = synthEn && !mEnPrev;
      expCal = (rise && !skipCal) ? 1 : 0;
      expDiv = bandSel;
      if (!synthEn || rise) begin
        for (int k = 0; k < 3; k++) mA[k] = 0;
        mC2d = 0; mC3d = 0; mC3dd = 0;
        expMod = mInt;
      end else begin
        inV = mFrac;
        for (int k = 0; k < 3; k++) begin
          mA[k] += inV;
          c[k] = (mA[k] >= DEN) ? 1 : 0;
          if (c[k] != 0) mA[k] -= DEN;
          inV = mA[k];
        end
        y = c[0] + c[1] - mC2d + c[2] - 2 * mC3d + mC3dd;
        expMod = mInt + y;
        mC3dd = mC3d; mC3d = c[2]; mC2d = c[1];
      end
      mFrac = s; mInt = ni; mEnPrev = synthEn;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-cycle comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (rstN && !done) begin
      cycles++;
      check(int'(modulus) == expMod, "R6 modulus", int'(modulus), expMod);
      check(int'(calReq) == expCal, "R8 calReq", int'(calReq), expCal);
      check(int'(outDivSel) == expDiv, "R2 outDivSel", int'(outDivSel), expDiv);
    end
  end

  task automatic cfg(input bit bs, input int band, input int fr, input bit rx,
                     input int dev, input bit tx);
    @(negedge clk);
    bandSel = bs; bandField = 5'(band); chanFrac = 16'(fr);
    rxMode = rx; devWord = 10'(dev); txData = tx;
  endtask

  task automatic avgCheck(input string req, input real ideal);
    longint sum = 0;
    real mean, err;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NAVG; i++) begin
      @(negedge clk);
      sum += longint'(modulus);
    end
    mean = real'(sum) / real'(NAVG);
    err  = mean - ideal;
    if (err < 0.0) err = -err;
    check(err < 0.001, req, int'(mean * 1000.0), int'(ideal * 1000.0));
  endtask

  function automatic real ideal(input bit bs, input int band, input int fr,
                                input bit rx, input int dev, input bit tx);
    int d;
    if (rx) d = bs ? -3000 : -6000;
    else    d = (tx ? 1 : -1) * dev * (bs ? 2 : 4);
    return real'(BASE + band) + real'(fr + d) / real'(DEN);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 reset state
    check(modulus == 8'd0, "R1 modulus", int'(modulus), 0);
    check(calReq == 1'b0, "R1 calReq", int'(calReq), 0);
    check(outDivSel == 1'b0, "R1 outDivSel", int'(outDivSel), 0);
    rstN = 1'b1;

    // R7 disabled: exact integer part, fraction ignored
    cfg(0, 10, 20000, 0, 100, 1);
    repeat (3) @(negedge clk);
    check(int'(modulus) == BASE + 10, "R7 disabled modulus", int'(modulus), BASE + 10);

    // R8 enable rise -> one-cycle calReq on next clock
    synthEn = 1'b1;
    @(negedge clk);
    check(calReq == 1'b1, "R8 cal pulse", int'(calReq), 1);
    check(int'(modulus) == BASE + 10, "R7 first enabled cycle", int'(modulus), BASE + 10);
    @(negedge clk);
    check(calReq == 1'b0, "R8 cal width", int'(calReq), 0);

    // R3 R4 low band mark / space / receive
    avgCheck("R4 low mark", ideal(0, 10, 20000, 0, 100, 1));
    cfg(0, 10, 20000, 0, 100, 0);
    avgCheck("R4 low space", ideal(0, 10, 20000, 0, 100, 0));
    cfg(0, 10, 20000, 1, 100, 1);
    avgCheck("R3 low receive", ideal(0, 10, 20000, 1, 100, 1));
    cfg(0, 10, 20000, 1, 700, 0);
    avgCheck("R4 receive ignores tx", ideal(0, 10, 20000, 1, 100, 1));

    // R3 high band
    cfg(1, 7, 20000, 0, 100, 1);
    avgCheck("R3 high mark", ideal(1, 7, 20000, 0, 100, 1));
    cfg(1, 7, 20000, 0, 100, 0);
    avgCheck("R3 high space", ideal(1, 7, 20000, 0, 100, 0));
    cfg(1, 7, 20000, 1, 100, 0);
    avgCheck("R3 high receive", ideal(1, 7, 20000, 1, 100, 0));

    // R5 borrow and carry
    cfg(0, 12, 3000, 1, 0, 0);
    avgCheck("R5 borrow", ideal(0, 12, 3000, 1, 0, 0));
    cfg(0, 12, 63900, 0, 100, 1);
    avgCheck("R5 carry", ideal(0, 12, 63900, 0, 100, 1));

    // R8 skip on re-enable; R9 one-cycle latency via model compare
    synthEn = 1'b0; skipCal = 1'b1;
    repeat (3) @(negedge clk);
    check(int'(modulus) == BASE + 13, "R7 disabled after carry", int'(modulus), BASE + 13);
    synthEn = 1'b1;
    @(negedge clk);
    check(calReq == 1'b0, "R8 skipped cal", int'(calReq), 0);
    cfg(0, 3, 32000, 0, 0, 1);
    @(negedge clk);
    check(int'(modulus) == expMod, "R9 latency", int'(modulus), expMod);
    avgCheck("R6 half fraction", ideal(0, 3, 32000, 0, 0, 1));

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule